// File: doc/BRIEF.md
# External Bus Write-Cycle Master

This block turns single write commands from an on-chip requester into transfers on a synchronous external bus. The bus has an address, a data bus, a two-bit size code, a read/write line, and three active-low strobes. The start strobe `bus_ts_n` marks the first clock of a transfer. The in-progress strobe `bus_tip_n` frames the whole transfer. The slave drives the acknowledge `bus_ta_n`. The requester offers a command (address, data, size) on a valid/ready handshake. The master then puts the address phase on the bus and drives the write data. It waits for the slave to acknowledge, and then reports the result with a one-cycle pulse.

A transfer starts with one start-strobe clock. Any number of wait clocks follow until the acknowledge is sampled low on a rising edge. A fast slave may acknowledge during the start-strobe clock itself. The transfer then ends after two clock edges, with no wait state. If no acknowledge arrives within a parameterized number of wait clocks, the master gives up. It releases the bus and raises a timeout pulse in place of the done pulse.

Top module: `ebus_wr_master`

## Requirements
- R1: After synchronous reset, `cmd_ready`=1 and `bus_ts_n`=1 and `bus_tip_n`=1. Also `bus_rnw`=1, `bus_data_oe`=0, `done`=0 and `timeout`=0.
- R2: A command is taken only on a rising edge where `cmd_valid`=1 and `cmd_ready`=1. `cmd_ready` is 0 in every clock from the start-strobe clock until the transfer ends.
- R3: In the clock after a command is taken, the bus shows the start-strobe clock. In that clock, `bus_ts_n`=0, `bus_tip_n`=0 and `bus_rnw`=0 (0 is the write level), and `bus_addr`/`bus_size` equal the command's values. `bus_ts_n` is low for exactly one clock per transfer.
- R4: `bus_data_oe`=1 and `bus_data_o` equals the command data from the start-strobe clock until the acknowledge is sampled. `bus_data_oe` is 0 in every other clock.
- R5: When `bus_ta_n`=0 is sampled on a rising edge during a wait clock, `done`=1 for exactly one clock after that edge. In that same clock, `bus_tip_n`=1, `bus_data_oe`=0 and `cmd_ready`=1.
- R6: Fast termination. When `bus_ta_n`=0 is sampled on the rising edge that ends the start-strobe clock, the next clock has `done`=1 and `bus_tip_n`=1. No wait clock appears in that transfer.
- R7: `bus_addr`, `bus_size` and `bus_rnw` hold steady for the whole transfer. Changes on `cmd_addr`, `cmd_data` and `cmd_size` after acceptance have no effect on the bus.
- R8: Suppose no acknowledge is sampled during the `TIMEOUT_CYC` wait clocks after the start-strobe clock. The master then returns to idle. In the next clock, `timeout`=1 for one clock, `done`=0 and `bus_tip_n`=1.
- R9: A command presented in the idle clock that directly follows a completed transfer is accepted at once. Its start-strobe clock follows on the next clock.
- R10: `bus_ta_n`=0 while idle is ignored: `done` stays 0 and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Master idle and able to take a command |
| cmd_addr | input | 32 | Command address |
| cmd_data | input | 32 | Command write data |
| cmd_size | input | 2 | Command transfer size code |
| done | output | 1 | One-clock pulse: transfer acknowledged |
| timeout | output | 1 | One-clock pulse: transfer abandoned |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | Bus transfer size |
| bus_rnw | output | 1 | Read/write line, 0 = write |
| bus_ts_n | output | 1 | Transfer start strobe, active low |
| bus_tip_n | output | 1 | Transfer in progress, active low |
| bus_ta_n | input | 1 | Transfer acknowledge from slave, active low |
| bus_data_o | output | 32 | Write data |
| bus_data_oe | output | 1 | Data output enable |

## Verification
A wrong sequencer state shows at the strobes in the very next clock. A skipped start state gives no low `bus_ts_n`. A stuck start state gives a second start-strobe clock. A missed acknowledge keeps `bus_tip_n` low past the clock where `done` should rise. A wrong wait counter moves the `timeout` pulse by a clock or more away from the clock `TIMEOUT_CYC` wait clocks after the start-strobe clock. Corrupted command capture shows on `bus_addr` or `bus_data_o` during the start-strobe clock. The directed scenarios sample every one of these clocks.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } wbm_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SIZE_W-1:0] size;
    } wbm_cmd_t;

    function automatic logic busy(input wbm_state_e s);
        return (s == ST_START) || (s == ST_WAIT);
    endfunction

endpackage

// File: rtl/wbm_cmd_reg.sv
module wbm_cmd_reg
    import wbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  wbm_cmd_t cmd_in,
    output wbm_cmd_t cmd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q <= cmd_in;
        end
    end

endmodule

// File: rtl/wbm_seq.sv
module wbm_seq
    import wbm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       ta_n,
    output wbm_state_e state,
    output logic       accept,
    output logic       done,
    output logic       timeout
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    wbm_state_e       state_d;
    logic [CNT_W-1:0] wait_cnt;
    logic             ack;
    logic             expire;

    assign accept = (state == ST_IDLE) && cmd_valid;
    assign ack    = busy(state) && !ta_n;
    assign expire = (state == ST_WAIT) && ta_n && (wait_cnt == CNT_LAST);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_d = ST_START;
            ST_START: state_d = ack ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (ack || expire) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            done     <= 1'b0;
            timeout  <= 1'b0;
        end else begin
            state    <= state_d;
            done     <= ack;
            timeout  <= expire;
            if (state == ST_WAIT) wait_cnt <= wait_cnt + 1'b1;
            else                  wait_cnt <= '0;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_DONE_XOR_TMO: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout)); // R8
    AST_TMO_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (state != ST_WAIT)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (wait_cnt < CNT_W'(TIMEOUT_CYC))); // R8

endmodule

// File: rtl/ebus_wr_master.sv
module ebus_wr_master
    import wbm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [SIZE_W-1:0] cmd_size,
    output logic              done,
    output logic              timeout,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [SIZE_W-1:0] bus_size,
    output logic              bus_rnw,
    output logic              bus_ts_n,
    output logic              bus_tip_n,
    input  logic              bus_ta_n,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe
);

    wbm_state_e state;
    logic       accept;
    wbm_cmd_t   cmd_in;
    wbm_cmd_t   cmd_q;

    assign cmd_in = '{addr: cmd_addr, data: cmd_data, size: cmd_size};

    wbm_cmd_reg u_cmd (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .cmd_in (cmd_in),
        .cmd_q  (cmd_q)
    );

    wbm_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .ta_n      (bus_ta_n),
        .state     (state),
        .accept    (accept),
        .done      (done),
        .timeout   (timeout)
    );

    assign cmd_ready   = (state == ST_IDLE);
    assign bus_addr    = cmd_q.addr;
    assign bus_size    = cmd_q.size;
    assign bus_data_o  = cmd_q.data;
    assign bus_rnw     = !busy(state);
    assign bus_tip_n   = !busy(state);
    assign bus_ts_n    = (state != ST_START);
    assign bus_data_oe = busy(state);

    AST_TS_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        !bus_ts_n |=> bus_ts_n); // R3
    AST_TS_IN_TIP: assert property (@(posedge clk) disable iff (rst)
        !bus_ts_n |-> (!bus_tip_n && !bus_rnw)); // R3
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (bus_tip_n && !bus_data_oe)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_tip_n && bus_ts_n) |-> ($stable(bus_addr) && $stable(bus_size))); // R7
    AST_OE_FRAMED: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> !bus_tip_n); // R4

endmodule

// File: tb/tb_ebus_wr_master.sv
module tb_ebus_wr_master;

    localparam int TMO = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_data;
    logic [1:0]  cmd_size;
    logic        done;
    logic        timeout;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_rnw;
    logic        bus_ts_n;
    logic        bus_tip_n;
    logic        bus_ta_n;
    logic [31:0] bus_data_o;
    logic        bus_data_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    ebus_wr_master #(.TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_size(cmd_size),
        .done(done), .timeout(timeout), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rnw(bus_rnw), .bus_ts_n(bus_ts_n), .bus_tip_n(bus_tip_n),
        .bus_ta_n(bus_ta_n), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Drive command at a negedge; returns at the negedge inside the start-strobe clock.
    task automatic issue(input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] s, input bit fast);
        cmd_valid = 1'b1; cmd_addr = a; cmd_data = d; cmd_size = s;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr = ~a; cmd_data = ~d; cmd_size = ~s;   // R7: late changes
        bus_ta_n = fast ? 1'b0 : 1'b1;
        chk("R3", "ts_n", 32'(bus_ts_n), 0);
        chk("R3", "tip_n", 32'(bus_tip_n), 0);
        chk("R3", "rnw", 32'(bus_rnw), 0);
        chk("R3", "addr", bus_addr, a);
        chk("R3", "size", 32'(bus_size), 32'(s));
        chk("R4", "oe start", 32'(bus_data_oe), 1);
        chk("R4", "data start", bus_data_o, d);
        chk("R2", "ready busy", 32'(cmd_ready), 0);
    endtask

    task automatic expect_done(input string tag);
        chk(tag, "done", 32'(done), 1);
        chk(tag, "timeout", 32'(timeout), 0);
        chk(tag, "tip_n end", 32'(bus_tip_n), 1);
        chk("R4", "oe end", 32'(bus_data_oe), 0);
        chk(tag, "ready end", 32'(cmd_ready), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1; cmd_valid = 1'b0; bus_ta_n = 1'b1;
        cmd_addr = '0; cmd_data = '0; cmd_size = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready", 32'(cmd_ready), 1);
        chk("R1", "ts_n", 32'(bus_ts_n), 1);
        chk("R1", "tip_n", 32'(bus_tip_n), 1);
        chk("R1", "rnw", 32'(bus_rnw), 1);
        chk("R1", "oe", 32'(bus_data_oe), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "timeout", 32'(timeout), 0);
    endtask

    task automatic t_normal(input logic [31:0] a, input logic [31:0] d,
                            input logic [1:0] s, input int waits);
        issue(a, d, s, 0);
        for (int w = 1; w <= waits; w++) begin
            @(negedge clk);
            chk("R3", "ts_n wait", 32'(bus_ts_n), 1);
            chk("R5", "tip_n wait", 32'(bus_tip_n), 0);
            chk("R4", "data wait", bus_data_o, d);
            chk("R4", "oe wait", 32'(bus_data_oe), 1);
            chk("R7", "addr hold", bus_addr, a);
            chk("R7", "size hold", 32'(bus_size), 32'(s));
            chk("R7", "rnw hold", 32'(bus_rnw), 0);
            chk("R5", "no early done", 32'(done), 0);
            if (w == waits) bus_ta_n = 1'b0;
        end
        @(negedge clk);
        bus_ta_n = 1'b1;
        expect_done("R5");
        @(negedge clk);
        chk("R5", "done one clk", 32'(done), 0);
    endtask

    task automatic t_fast(input logic [31:0] a, input logic [31:0] d);
        issue(a, d, 2'd1, 1);
        @(negedge clk);
        bus_ta_n = 1'b1;
        expect_done("R6");
        chk("R6", "ts_n after", 32'(bus_ts_n), 1);
        @(negedge clk);
        chk("R6", "done one clk", 32'(done), 0);
    endtask

    task automatic t_back2back();
        issue(32'h1000_0040, 32'hCAFE_0001, 2'd2, 1);
        @(negedge clk);
        bus_ta_n = 1'b1;
        expect_done("R9");
        issue(32'h2000_0080, 32'hCAFE_0002, 2'd3, 1);   // R9 accepted in done clock
        @(negedge clk);
        bus_ta_n = 1'b1;
        expect_done("R9");
    endtask

    task automatic t_timeout();
        issue(32'h0BAD_0000, 32'h5555_AAAA, 2'd0, 0);
        for (int w = 1; w <= TMO; w++) begin
            @(negedge clk);
            chk("R8", "tip_n held", 32'(bus_tip_n), 0);
            chk("R8", "no early tmo", 32'(timeout), 0);
        end
        @(negedge clk);
        chk("R8", "timeout", 32'(timeout), 1);
        chk("R8", "no done", 32'(done), 0);
        chk("R8", "tip_n released", 32'(bus_tip_n), 1);
        chk("R8", "oe off", 32'(bus_data_oe), 0);
        @(negedge clk);
        chk("R8", "timeout one clk", 32'(timeout), 0);
    endtask

    task automatic t_ta_idle();
        bus_ta_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R10", "done idle", 32'(done), 0);
            chk("R10", "tip_n idle", 32'(bus_tip_n), 1);
            chk("R10", "ts_n idle", 32'(bus_ts_n), 1);
        end
        bus_ta_n = 1'b1;
        @(negedge clk);
        chk("R10", "done after", 32'(done), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        t_reset();
        t_normal(32'h8000_0010, 32'hDEAD_BEEF, 2'd0, 1);
        t_normal(32'h0000_FFFC, 32'h1234_5678, 2'd2, 3);
        t_fast(32'h4000_0004, 32'hA5A5_5A5A);
        t_back2back();
        t_timeout();
        t_ta_idle();
        t_normal(32'hFFFF_FFF0, 32'h0F0F_0F0F, 2'd3, TMO);
        finish_run();
    end

endmodule